// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small blitter for a linear framebuffer held in a byte-wide synchronous RAM. Given one command, it either paints a solid rectangle with a colour or moves a rectangle of pixels from one place on the screen to another. Pixels are `bpp_i` bytes wide. One screen line takes `bpp_i * screen_w_i` bytes, so the byte address of pixel (x, y) is `bpp*x + bpp*screen_w*y`.

A copy chooses its row order and its byte order from where the source and destination lie, so that a copy between overlapping rectangles gives the same picture as a copy made through a temporary buffer. A fill first writes the colour bytes across the first destination row. Every later row is then copied from that first row. When the work ends, the block presents the destination rectangle for one cycle as a region that needs redrawing.

The RAM port returns read data one cycle after a read request. Commands use a start/busy/done handshake.

Top module: `rect_blit_engine`

## Requirements
- R1: The byte address of byte b of pixel (x, y) is `bpp*x + bpp*screen_w*y + b`, taken modulo the RAM size.
- R2: After a copy (op_i=1), the destination rectangle holds the bytes the source rectangle held before the command. This is true even when the two rectangles overlap. Bytes outside the destination are unchanged.
- R3: When the destination y is greater than the source y, a copy processes rows from the last row up to the first. In every other case it processes rows from the first row down. Its first write therefore falls in the last destination row in the first case and in the first destination row otherwise.
- R4: When the source and destination share the same y and the destination x is greater than the source x, each row is moved from its last byte to its first. The first write is then the last byte of the first row. In every other case bytes move from first to last.
- R5: After a fill (op_i=0), byte k of every destination pixel equals `colour_i[8k+7:8k]` for k < bpp. No other byte changes.
- R6: A fill writes row 0 straight from the colour. Every read it issues lies within the first destination row, which is the row source for all later rows.
- R7: A start is accepted only when busy_o is low. busy_o rises in the cycle after an accepted start. A start raised while busy_o is high has no effect on the running command or on its result.
- R8: done_o is a single-cycle pulse and ends the busy period. While done_o is high, dirty_x_o, dirty_y_o, dirty_w_o and dirty_h_o equal the destination x, y, width and height of the command.
- R9: A command with zero width or zero height makes no memory access. It stays busy for exactly one cycle, the done cycle.
- R10: After reset, busy_o, done_o and mem_req_o are low.
- R11: Each copied byte takes one read cycle followed directly by one write cycle, and each byte of fill row 0 takes one write cycle. With n = bpp*w, a copy is busy for 2*n*h+1 cycles and a fill for n+2*n*(h-1)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| op_i | input | 1 | 0 = fill, 1 = copy |
| colour_i | input | 8*BPP_MAX | Fill colour, byte k for pixel byte k |
| src_x_i | input | COORD_W | Copy source x |
| src_y_i | input | COORD_W | Copy source y |
| dst_x_i | input | COORD_W | Destination x |
| dst_y_i | input | COORD_W | Destination y |
| width_i | input | COORD_W | Rectangle width in pixels |
| height_i | input | COORD_W | Rectangle height in pixels |
| bpp_i | input | BPP_W | Bytes per pixel, 1..BPP_MAX |
| screen_w_i | input | COORD_W | Screen width in pixels |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dirty_x_o | output | COORD_W | Redraw region x |
| dirty_y_o | output | COORD_W | Redraw region y |
| dirty_w_o | output | COORD_W | Redraw region width |
| dirty_h_o | output | COORD_W | Redraw region height |
| mem_req_o | output | 1 | RAM access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after a read |

## Verification
Copies are tried with vertical overlap in both directions, with horizontal overlap on the same row in both directions, and with disjoint rectangles. The final RAM is compared against a buffered reference, and the first write address is checked; together these separate a correct order choice from a wrong row order or a wrong byte order. Fills are tried at 1 to 4 bytes per pixel with single-row and multi-row heights. The fill read addresses show that later rows come from the first row, and the colour byte placement shows that little-endian order is kept. Zero-sized commands, starts raised while busy, and fully random commands with exact busy-cycle counts cover the handshake and the per-byte cycle cost.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } blit_state_e;

  typedef enum logic {
    OP_FILL = 1'b0,
    OP_COPY = 1'b1
  } blit_op_e;
endpackage

// File: rtl/rect_blit_addr.sv
// Byte address of (x, y+row) plus byte offset in a linear framebuffer (R1)
module rect_blit_addr #(
  parameter int COORD_W = 8,
  parameter int BPP_W   = 3,
  parameter int LEN_W   = 11,
  parameter int ADDR_W  = 12
) (
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [COORD_W-1:0] scr_w_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [LEN_W-1:0]   byte_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] line;

  always_comb begin
    stride = ADDR_W'(bpp_i) * ADDR_W'(scr_w_i);
    line   = ADDR_W'(y_i) + ADDR_W'(row_i);
    addr_o = ADDR_W'(bpp_i) * ADDR_W'(x_i) + stride * line + ADDR_W'(byte_i);
  end
endmodule

// File: rtl/rect_blit_walk.sv
// Logical row/byte counters mapped to physical row/byte by direction
module rect_blit_walk #(
  parameter int COORD_W = 8,
  parameter int BPP_W   = 3,
  parameter int LEN_W   = 11,
  parameter int CIDX_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [COORD_W-1:0] rows_i,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic               rows_up_i,
  input  logic               rtl_i,
  output logic [COORD_W-1:0] row_o,
  output logic [LEN_W-1:0]   byte_o,
  output logic [CIDX_W-1:0]  cidx_o,
  output logic               first_row_o,
  output logic               row_last_o,
  output logic               all_last_o
);
  logic [LEN_W-1:0]   k_q;
  logic [COORD_W-1:0] r_q;
  logic [CIDX_W-1:0]  c_q;
  logic               c_wrap;

  assign row_last_o  = (k_q == len_i - LEN_W'(1));
  assign all_last_o  = row_last_o && (r_q == rows_i - COORD_W'(1));
  assign first_row_o = (r_q == '0);
  assign row_o       = rows_up_i ? (rows_i - COORD_W'(1) - r_q) : r_q;
  assign byte_o      = rtl_i ? (len_i - LEN_W'(1) - k_q) : k_q;
  assign cidx_o      = c_q;
  assign c_wrap      = (BPP_W'(c_q) == bpp_i - BPP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (clear_i) begin
      k_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (step_i) begin
      c_q <= c_wrap ? '0 : c_q + CIDX_W'(1);
      if (row_last_o) begin
        k_q <= '0;
        r_q <= r_q + COORD_W'(1);
      end else begin
        k_q <= k_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/rect_blit_ctrl.sv
// Sequencer: read-then-write per copied byte, write-only for fill row 0
module rect_blit_ctrl
  import rect_blit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        empty_i,
  input  logic        fill_now_i,
  input  logic        fill_q_i,
  input  logic        first_row_i,
  input  logic        row_last_i,
  input  logic        all_last_i,
  output logic        accept_o,
  output logic        step_o,
  output blit_state_e state_o
);
  blit_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_WRITE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (empty_i)         state_d = ST_DONE;
        else if (fill_now_i) state_d = ST_WRITE;
        else                 state_d = ST_READ;
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (all_last_i)                                 state_d = ST_DONE;
        else if (fill_q_i && first_row_i && !row_last_i) state_d = ST_WRITE;
        else                                            state_d = ST_READ;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rect_blit_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int BPP_MAX = 4,
  parameter int ADDR_W  = 12,
  localparam int BPP_W  = $clog2(BPP_MAX + 1),
  localparam int CIDX_W = (BPP_MAX > 1) ? $clog2(BPP_MAX) : 1,
  localparam int LEN_W  = COORD_W + BPP_W,
  localparam int COL_W  = 8 * BPP_MAX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               op_i,
  input  logic [COL_W-1:0]   colour_i,
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [COORD_W-1:0] screen_w_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [COORD_W-1:0] dirty_x_o,
  output logic [COORD_W-1:0] dirty_y_o,
  output logic [COORD_W-1:0] dirty_w_o,
  output logic [COORD_W-1:0] dirty_h_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  logic               fill_q;
  logic [COL_W-1:0]   colour_q;
  logic [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q, scr_w_q;
  logic [BPP_W-1:0]   bpp_q;

  logic               accept, step;
  blit_state_e        state;
  logic [LEN_W-1:0]   len;
  logic               rows_up, rtl;
  logic [COORD_W-1:0] row;
  logic [LEN_W-1:0]   byte_idx;
  logic [CIDX_W-1:0]  cidx;
  logic               first_row, row_last, all_last;
  logic [ADDR_W-1:0]  src_addr, dst_addr;
  logic [COORD_W-1:0] src_x_sel, src_y_sel, src_row_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= 1'b0;
      colour_q <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      dx_q     <= '0;
      dy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      bpp_q    <= '0;
      scr_w_q  <= '0;
    end else if (accept) begin
      fill_q   <= (op_i == OP_FILL);
      colour_q <= colour_i;
      sx_q     <= src_x_i;
      sy_q     <= src_y_i;
      dx_q     <= dst_x_i;
      dy_q     <= dst_y_i;
      w_q      <= width_i;
      h_q      <= height_i;
      bpp_q    <= bpp_i;
      scr_w_q  <= screen_w_i;
    end
  end

  assign len     = LEN_W'(bpp_q) * LEN_W'(w_q);
  // Direction choice keeps overlapping copies equal to a buffered copy
  assign rows_up = !fill_q && (dy_q > sy_q);
  assign rtl     = !fill_q && (dy_q == sy_q) && (dx_q > sx_q);

  rect_blit_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .empty_i     ((width_i == '0) || (height_i == '0)),
    .fill_now_i  (op_i == OP_FILL),
    .fill_q_i    (fill_q),
    .first_row_i (first_row),
    .row_last_i  (row_last),
    .all_last_i  (all_last),
    .accept_o    (accept),
    .step_o      (step),
    .state_o     (state)
  );

  rect_blit_walk #(
    .COORD_W (COORD_W),
    .BPP_W   (BPP_W),
    .LEN_W   (LEN_W),
    .CIDX_W  (CIDX_W)
  ) i_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .step_i      (step),
    .len_i       (len),
    .rows_i      (h_q),
    .bpp_i       (bpp_q),
    .rows_up_i   (rows_up),
    .rtl_i       (rtl),
    .row_o       (row),
    .byte_o      (byte_idx),
    .cidx_o      (cidx),
    .first_row_o (first_row),
    .row_last_o  (row_last),
    .all_last_o  (all_last)
  );

  // Fill rows after the first take the first destination row as source
  assign src_x_sel   = fill_q ? dx_q : sx_q;
  assign src_y_sel   = fill_q ? dy_q : sy_q;
  assign src_row_sel = fill_q ? '0 : row;

  rect_blit_addr #(
    .COORD_W (COORD_W),
    .BPP_W   (BPP_W),
    .LEN_W   (LEN_W),
    .ADDR_W  (ADDR_W)
  ) i_src_addr (
    .bpp_i   (bpp_q),
    .scr_w_i (scr_w_q),
    .x_i     (src_x_sel),
    .y_i     (src_y_sel),
    .row_i   (src_row_sel),
    .byte_i  (byte_idx),
    .addr_o  (src_addr)
  );

  rect_blit_addr #(
    .COORD_W (COORD_W),
    .BPP_W   (BPP_W),
    .LEN_W   (LEN_W),
    .ADDR_W  (ADDR_W)
  ) i_dst_addr (
    .bpp_i   (bpp_q),
    .scr_w_i (scr_w_q),
    .x_i     (dx_q),
    .y_i     (dy_q),
    .row_i   (row),
    .byte_i  (byte_idx),
    .addr_o  (dst_addr)
  );

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = (state == ST_READ) ? src_addr : dst_addr;
  assign mem_wdata_o = (fill_q && first_row) ? colour_q[8*cidx +: 8] : mem_rdata_i;

  assign dirty_x_o = dx_q;
  assign dirty_y_o = dy_q;
  assign dirty_w_o = w_q;
  assign dirty_h_o = h_q;
endmodule

// File: rtl/rect_blit_checker.sv
module rect_blit_checker #(
  parameter int COORD_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [COORD_W-1:0] dirty_x_o,
  input logic [COORD_W-1:0] dirty_w_o
);
  AST_START_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);                                  // R7
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);                                           // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));                                  // R8
  AST_DONE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);                                            // R9
  AST_DIRTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(dirty_x_o) && $stable(dirty_w_o))); // R8
  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));             // R11
endmodule

bind rect_blit_engine rect_blit_checker #(.COORD_W(COORD_W)) i_chk (.*);

// File: tb/test_rect_blit_engine.sv
module test_rect_blit_engine;
  localparam int COORD_W = 8;
  localparam int BPP_MAX = 4;
  localparam int ADDR_W  = 12;
  localparam int MEM_N   = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, op;
  logic [31:0] colour;
  logic [COORD_W-1:0] sx, sy, dx, dy, w, h, scr_w;
  logic [2:0] bpp;
  logic busy, done, mem_req, mem_we;
  logic [COORD_W-1:0] dirty_x, dirty_y, dirty_w, dirty_h;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  logic [7:0] mem [MEM_N];
  logic [7:0] exp_mem [MEM_N];
  logic [7:0] tmp [MEM_N];

  // monitor state
  int wr_cnt, rd_cnt, bad_rd;
  logic seen_wr;
  logic [ADDR_W-1:0] first_wr;
  int fill_lo, fill_hi;
  logic fill_mon;

  always #10 clk = ~clk;  // 50 MHz

  rect_blit_engine #(.COORD_W(COORD_W), .BPP_MAX(BPP_MAX), .ADDR_W(ADDR_W)) i_rect_blit_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .colour_i(colour),
    .src_x_i(sx), .src_y_i(sy), .dst_x_i(dx), .dst_y_i(dy), .width_i(w), .height_i(h),
    .bpp_i(bpp), .screen_w_i(scr_w), .busy_o(busy), .done_o(done),
    .dirty_x_o(dirty_x), .dirty_y_o(dirty_y), .dirty_w_o(dirty_w), .dirty_h_o(dirty_h),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // synchronous RAM, one cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (!seen_wr) begin
          first_wr = mem_addr;
          seen_wr  = 1'b1;
        end
        wr_cnt++;
      end else begin
        mem_rdata <= mem[mem_addr];
        rd_cnt++;
        if (fill_mon && (int'(mem_addr) < fill_lo || int'(mem_addr) >= fill_hi)) bad_rd++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int baddr(int b_pp, int sw, int x, int y);
    return (b_pp * x + b_pp * sw * y) % MEM_N;
  endfunction

  function automatic int exp_cycles(bit is_copy, int b_pp, int ww, int hh);
    int n = b_pp * ww;
    if (ww == 0 || hh == 0) return 1;
    if (is_copy) return 2 * n * hh + 1;
    return n + 2 * n * (hh - 1) + 1;
  endfunction

  task automatic model(input bit is_copy, input int c, input int b_pp, input int sw,
                       input int x0, input int y0, input int x1, input int y1, input int ww, input int hh);
    int n = b_pp * ww;
    if (is_copy) begin
      for (int r = 0; r < hh; r++)
        for (int k = 0; k < n; k++)
          tmp[r * n + k] = exp_mem[(baddr(b_pp, sw, x0, y0 + r) + k) % MEM_N];
      for (int r = 0; r < hh; r++)
        for (int k = 0; k < n; k++)
          exp_mem[(baddr(b_pp, sw, x1, y1 + r) + k) % MEM_N] = tmp[r * n + k];
    end else begin
      for (int r = 0; r < hh; r++)
        for (int k = 0; k < n; k++)
          exp_mem[(baddr(b_pp, sw, x1, y1 + r) + k) % MEM_N] = 8'(c >> (8 * (k % b_pp)));
    end
  endtask

  task automatic run(input bit is_copy, input int c, input int b_pp, input int sw,
                     input int x0, input int y0, input int x1, input int y1,
                     input int ww, input int hh, input bit poke, input string tag);
    int cyc = 0, n, mism = 0, first_bad = -1, exp_first, r0, b0;
    bit got_done = 0;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; bad_rd = 0; seen_wr = 0;
    n = b_pp * ww;
    fill_mon = !is_copy;
    fill_lo = baddr(b_pp, sw, x1, y1);
    fill_hi = fill_lo + n;
    op = is_copy; colour = c; bpp = 3'(b_pp); scr_w = COORD_W'(sw);
    sx = COORD_W'(x0); sy = COORD_W'(y0); dx = COORD_W'(x1); dy = COORD_W'(y1);
    w = COORD_W'(ww); h = COORD_W'(hh);
    start = 1'b1;
    model(is_copy, c, b_pp, sw, x0, y0, x1, y1, ww, hh);
    for (int t = 0; t < 20000 && !got_done; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && t == 2) begin
        // R7: a start while busy must be ignored
        start = 1'b1; op = ~op; colour = ~colour; dx = 8'd1; dy = 8'd1; w = 8'd3; h = 8'd2;
      end
      if (busy) cyc++;
      if (done) begin
        got_done = 1;
        check(dirty_x == COORD_W'(x1) && dirty_y == COORD_W'(y1), "R8", {tag, " dirty xy"},
              {dirty_x, dirty_y}, {COORD_W'(x1), COORD_W'(y1)});
        check(dirty_w == COORD_W'(ww) && dirty_h == COORD_W'(hh), "R8", {tag, " dirty wh"},
              {dirty_w, dirty_h}, {COORD_W'(ww), COORD_W'(hh)});
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(got_done, "R8", {tag, " done seen"}, got_done, 1);
    check(!done && !busy, "R8", {tag, " done one cycle"}, {done, busy}, 0);
    check(cyc == exp_cycles(is_copy, b_pp, ww, hh), "R11", {tag, " busy cycles"}, cyc,
          exp_cycles(is_copy, b_pp, ww, hh));
    for (int a = 0; a < MEM_N; a++)
      if (mem[a] !== exp_mem[a]) begin
        mism++;
        if (first_bad < 0) first_bad = a;
      end
    check(mism == 0, is_copy ? "R2" : "R5", {tag, " ram image mismatches"}, mism, 0);
    if (ww == 0 || hh == 0) begin
      check(wr_cnt == 0 && rd_cnt == 0, "R9", {tag, " accesses"}, wr_cnt + rd_cnt, 0);
    end else begin
      r0 = (is_copy && y1 > y0) ? hh - 1 : 0;
      b0 = (is_copy && y1 == y0 && x1 > x0) ? n - 1 : 0;
      exp_first = (baddr(b_pp, sw, x1, y1 + r0) + b0) % MEM_N;
      check(int'(first_wr) == exp_first, (b0 != 0) ? "R4" : "R3", {tag, " first write (R1)"},
            first_wr, exp_first);
      if (!is_copy)
        check(bad_rd == 0, "R6", {tag, " fill reads outside first row"}, bad_rd, 0);
    end
    fill_mon = 0;
  endtask

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sw, b_pp, ww, hh, x0, y0, x1, y1, rows;
    bit cp;
    void'($urandom(32'd20240611));
    start = 0; op = 0; colour = 0; sx = 0; sy = 0; dx = 0; dy = 0; w = 0; h = 0;
    bpp = 3'd1; scr_w = 8'd16; fill_mon = 0; seen_wr = 0;
    mem_rdata = 8'h00;
    for (int a = 0; a < MEM_N; a++) begin
      mem[a] = 8'($urandom);
      exp_mem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R10", "reset outputs", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_req, "R10", "idle after reset", {busy, done, mem_req}, 0);

    // directed corner cases
    run(1, 0, 2, 20, 3, 4, 3, 6, 5, 5, 0, "R3 copy down overlap");
    run(1, 0, 2, 20, 3, 8, 4, 6, 5, 5, 0, "R3 copy up overlap");
    run(1, 0, 3, 20, 2, 5, 4, 5, 6, 3, 0, "R4 same row right");
    run(1, 0, 3, 20, 6, 5, 3, 5, 6, 3, 0, "R4 same row left");
    run(1, 0, 1, 30, 0, 0, 10, 10, 4, 4, 0, "R2 disjoint");
    run(0, 32'h11223344, 4, 16, 2, 3, 2, 3, 3, 1, 0, "R5 fill one row");
    run(0, 32'hA5B6C7D8, 3, 24, 0, 0, 5, 7, 4, 6, 0, "R6 fill rows bpp3");
    run(0, 32'h000000EE, 1, 40, 0, 0, 0, 0, 40, 2, 0, "R1 fill full width");
    run(1, 0, 2, 20, 1, 1, 2, 2, 0, 4, 0, "R9 zero width");
    run(0, 32'h12345678, 2, 20, 1, 1, 2, 2, 4, 0, 0, "R9 zero height");
    run(1, 0, 2, 20, 2, 2, 9, 9, 4, 3, 1, "R7 start while busy copy");
    run(0, 32'h55AA33CC, 4, 20, 0, 0, 9, 9, 3, 3, 1, "R7 start while busy fill");

    // random commands biased towards overlap
    for (int i = 0; i < 30; i++) begin
      b_pp = 1 + ($urandom % 4);
      sw = 12 + ($urandom % 29);
      rows = MEM_N / (b_pp * sw);
      if (rows > 24) rows = 24;
      ww = $urandom % 9;
      hh = $urandom % 9;
      if (hh > rows) hh = rows;
      cp = $urandom % 3 != 0;
      x0 = $urandom % (sw - ww + 1);
      y0 = $urandom % (rows - hh + 1);
      if ($urandom % 2) begin
        x1 = clampi(x0 + int'($urandom % 7) - 3, 0, sw - ww);
        y1 = clampi(y0 + int'($urandom % 7) - 3, 0, rows - hh);
        if ($urandom % 3 == 0) y1 = y0;
      end else begin
        x1 = $urandom % (sw - ww + 1);
        y1 = $urandom % (rows - hh + 1);
      end
      run(cp, int'($urandom), b_pp, sw, x0, y0, x1, y1, ww, hh, ($urandom % 4) == 0, "R2 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule